// File: doc/BRIEF.md
# Frame-Transfer CCD Gate Clock Sequencer

This block produces the logic-level gate enables for a frame-transfer image sensor made of an image section, a storage section and a serial output register. It sequences three kinds of vertical motion: a fast dump of the image section, a full move of the exposed image into storage, and a single-line shift from storage into the serial register. Between line shifts it clocks the serial register to read one line. While the sensor integrates, every line period ends with a blanking interval in which the antiblooming gate receives a burst of pulses.

A vertical-start pulse begins a field. In capture mode the sequencer integrates for a fixed number of line periods. A shutter setting, taken only at vertical start, can insert a dump of the image section at a chosen line period, so that exposure lasts only from the end of that dump to the frame move. After the frame move, each stored line is shifted and then read out. A done flag marks the end of the field. In flush mode the sequencer only dumps the image section and then returns to idle. All progress is paced by a pixel-rate clock enable. Level shifting and the analog drive stages sit outside this block.

Top module: `ccd_gate_sequencer`

## Requirements
- R1: After synchronous reset every output is low, and the outputs stay low until a vertical start arrives.
- R2: Every transfer cycle on a gate takes two enabled ticks, high and then low. A capture with no mid-field dump gives exactly N_VERT image-gate pulses, and all of them fall in the frame move, where the storage gate pulses together with the image gates.
- R3: A dump gives N_VERT pulses on both image-gate phases, in phase with each other, while the storage gate stays low. Flush mode (mode_sel=1) performs only the dump: no storage, serial, antiblooming or done activity.
- R4: A shutter value s with 1 <= s < FIELD_LINES inserts a dump before line period s. The time from the last dump pulse falling to the first frame-move pulse rising is 1 + (FIELD_LINES - s) * (LINE_ACT + 2*AB_PULSES) ticks. The value 0, or any value >= FIELD_LINES, gives no mid-field dump.
- R5: After the frame move, N_LINES lines are read. Each line is one storage-gate pulse followed by N_SER serial-gate pulses. line_valid_o is high around every serial pulse and low for all others.
- R6: The storage gate and the serial gate are never high together. The storage gate rises only when the serial gate was low in the previous cycle.
- R7: Each of the FIELD_LINES integration line periods ends with AB_PULSES antiblooming pulses. The antiblooming gate is never high together with any other gate.
- R8: frame_done_o is a one-cycle pulse, raised once per capture after the last line has been read.
- R9: A vertical start outside idle is ignored. shutter_line and mode_sel are used only at the accepted vertical start.
- R10: The sequencer advances only on cycles with pix_ce high. With an enable every K cycles, all durations scale by K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_ce | input | 1 | Pixel-rate tick enable |
| vstart | input | 1 | Vertical-start pulse, accepted in idle |
| mode_sel | input | 1 | 0 = capture field, 1 = flush only |
| shutter_line | input | SHUT_W | Line period of the mid-field dump, 0 = none |
| iag1_o | output | 1 | Image-section gate, phase 1 |
| iag2_o | output | 1 | Image-section gate, phase 2 |
| sag_o | output | 1 | Storage-section gate |
| srg_o | output | 1 | Serial-register gate |
| abg_o | output | 1 | Antiblooming gate |
| line_valid_o | output | 1 | High while a line is read |
| frame_done_o | output | 1 | One-cycle end-of-field pulse |

## Verification
Every gate output and line_valid_o follows the internal state by one registered clock, and frame_done_o rises on the same clock as the return to idle. Because the outputs of a field lag the state by a constant amount, the bench measures intervals between output edges, which removes the lag. It expects the dump-to-frame-move interval to equal the R4 tick count multiplied by the enable spacing. The bench samples on the falling clock edge, counts rising edges of each output, waits for the done pulse plus a margin of several ticks, and only then compares per-field totals. For flush, which has no done pulse, it waits a computed number of ticks before comparing.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_INTEGRATE,
    ST_FRAME_XFER,
    ST_LINE_SHIFT,
    ST_LINE_READ,
    ST_BLANK
  } seq_state_t;
endpackage

// File: rtl/ccd_seq_counter.sv
module ccd_seq_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc)   q <= q + W'(1);
  end
endmodule

// File: rtl/ccd_gate_encoder.sv
module ccd_gate_encoder
  import ccd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t st_i,
  input  logic       hi_i,
  output logic       iag1_o,
  output logic       iag2_o,
  output logic       sag_o,
  output logic       srg_o,
  output logic       abg_o,
  output logic       lv_o
);
  logic vert_img;
  logic vert_sto;
  assign vert_img = (st_i == ST_CLEAR) || (st_i == ST_FRAME_XFER);
  assign vert_sto = (st_i == ST_FRAME_XFER) || (st_i == ST_LINE_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      iag1_o <= 1'b0;
      iag2_o <= 1'b0;
      sag_o  <= 1'b0;
      srg_o  <= 1'b0;
      abg_o  <= 1'b0;
      lv_o   <= 1'b0;
    end else begin
      iag1_o <= hi_i && vert_img;
      iag2_o <= hi_i && vert_img;
      sag_o  <= hi_i && vert_sto;
      srg_o  <= hi_i && (st_i == ST_LINE_READ);
      abg_o  <= hi_i && (st_i == ST_BLANK);
      lv_o   <= (st_i == ST_LINE_READ);
    end
  end

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    !(sag_o && srg_o));
  p_sag_after_srg_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sag_o) |-> !$past(srg_o));
  p_abg_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    abg_o |-> !(iag1_o || iag2_o || sag_o || srg_o));
  p_clear_sag_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (st_i == ST_CLEAR) |=> !sag_o);
endmodule

// File: rtl/ccd_gate_sequencer.sv
module ccd_gate_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int N_VERT      = 244,
  parameter int N_LINES     = 244,
  parameter int N_SER       = 339,
  parameter int FIELD_LINES = 262,
  parameter int LINE_ACT    = 760,
  parameter int AB_PULSES   = 17,
  parameter int SHUT_W      = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_ce,
  input  logic              vstart,
  input  logic              mode_sel,
  input  logic [SHUT_W-1:0] shutter_line,
  output logic              iag1_o,
  output logic              iag2_o,
  output logic              sag_o,
  output logic              srg_o,
  output logic              abg_o,
  output logic              line_valid_o,
  output logic              frame_done_o
);
  // Tick budgets per state: two ticks per gate transfer cycle (R2)
  localparam int T_CLR = 2 * N_VERT;
  localparam int T_INT = LINE_ACT;
  localparam int T_BLK = 2 * AB_PULSES;
  localparam int T_XFR = 2 * N_VERT;
  localparam int T_SHF = 2;
  localparam int T_RD  = 2 * N_SER;
  localparam int T_M1  = (T_RD > T_XFR) ? T_RD : T_XFR;
  localparam int T_M2  = (T_M1 > T_INT) ? T_M1 : T_INT;
  localparam int T_MAX = (T_M2 > T_BLK) ? T_M2 : T_BLK;
  localparam int TW    = $clog2(T_MAX);
  localparam int L_MAX = (FIELD_LINES > N_LINES) ? FIELD_LINES : N_LINES;
  localparam int LW    = $clog2(L_MAX + 1);

  seq_state_t    st, st_nx;
  logic [TW-1:0] tick, tick_lim;
  logic [LW-1:0] line, line_nx, shut_q;
  logic          mode_q, done_q;
  logic          adv, tick_last, line_inc, line_clr, done_set, shut_hit;
  logic          take_start;

  always_comb begin
    case (st)
      ST_CLEAR:      tick_lim = TW'(T_CLR - 1);
      ST_INTEGRATE:  tick_lim = TW'(T_INT - 1);
      ST_BLANK:      tick_lim = TW'(T_BLK - 1);
      ST_FRAME_XFER: tick_lim = TW'(T_XFR - 1);
      ST_LINE_SHIFT: tick_lim = TW'(T_SHF - 1);
      ST_LINE_READ:  tick_lim = TW'(T_RD - 1);
      default:       tick_lim = '0;
    endcase
  end

  // Progress only on enabled ticks (R10)
  assign adv        = pix_ce && (st != ST_IDLE);
  assign tick_last  = adv && (tick == tick_lim);
  assign line_nx    = line + LW'(1);
  assign shut_hit   = (shut_q != '0) && (line_nx == shut_q);
  assign take_start = (st == ST_IDLE) && vstart;

  always_comb begin
    st_nx    = st;
    line_inc = 1'b0;
    line_clr = 1'b0;
    done_set = 1'b0;
    case (st)
      ST_IDLE:
        if (vstart) st_nx = mode_sel ? ST_CLEAR : ST_INTEGRATE;
      ST_CLEAR:
        if (tick_last) st_nx = mode_q ? ST_IDLE : ST_INTEGRATE;
      ST_INTEGRATE:
        if (tick_last) st_nx = ST_BLANK;
      ST_BLANK:
        if (tick_last) begin
          if (line == LW'(FIELD_LINES - 1)) st_nx = ST_FRAME_XFER;
          else begin
            line_inc = 1'b1;
            st_nx    = shut_hit ? ST_CLEAR : ST_INTEGRATE;   // shutter dump (R4)
          end
        end
      ST_FRAME_XFER:
        if (tick_last) begin
          st_nx    = ST_LINE_SHIFT;
          line_clr = 1'b1;
        end
      ST_LINE_SHIFT:
        if (tick_last) st_nx = ST_LINE_READ;
      ST_LINE_READ:
        if (tick_last) begin
          if (line == LW'(N_LINES - 1)) begin
            st_nx    = ST_IDLE;
            done_set = 1'b1;                                 // R8
          end else begin
            line_inc = 1'b1;
            st_nx    = ST_LINE_SHIFT;                        // R5, R6
          end
        end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      shut_q <= '0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= done_set;
      if (take_start) begin                                  // R9
        mode_q <= mode_sel;
        shut_q <= (!mode_sel && (int'(shutter_line) < FIELD_LINES))
                  ? LW'(shutter_line) : '0;
      end
    end
  end

  ccd_seq_counter #(.W(TW)) u_tick (
    .clk (clk),
    .rst (rst),
    .clr ((st == ST_IDLE) || tick_last),
    .inc (adv),
    .q   (tick)
  );

  ccd_seq_counter #(.W(LW)) u_line (
    .clk (clk),
    .rst (rst),
    .clr (line_clr || (st == ST_IDLE)),
    .inc (line_inc),
    .q   (line)
  );

  // Registered gate outputs, low after reset (R1)
  ccd_gate_encoder u_enc (
    .clk    (clk),
    .rst    (rst),
    .st_i   (st),
    .hi_i   (~tick[0]),
    .iag1_o (iag1_o),
    .iag2_o (iag2_o),
    .sag_o  (sag_o),
    .srg_o  (srg_o),
    .abg_o  (abg_o),
    .lv_o   (line_valid_o)
  );

  assign frame_done_o = done_q;

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_done_from_read_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(st) == ST_LINE_READ));
  p_sample_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> ($stable(shut_q) && $stable(mode_q)));
  p_hold_no_ce_r10: assert property (@(posedge clk) disable iff (rst)
    (!pix_ce && (st != ST_IDLE)) |=> ($stable(st) && $stable(tick)));
endmodule

// File: tb/ccd_gate_sequencer_tb.sv
module ccd_gate_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam int NL = 4;
  localparam int NS = 6;
  localparam int F  = 6;
  localparam int LA = 4;
  localparam int AB = 2;
  localparam int SW = 4;
  localparam int LP = LA + 2 * AB;

  logic clk = 1'b0, rst = 1'b1, pix_ce = 1'b0, vstart = 1'b0, mode_sel = 1'b0;
  logic [SW-1:0] shutter_line = '0;
  logic iag1_o, iag2_o, sag_o, srg_o, abg_o, line_valid_o, frame_done_o;

  ccd_gate_sequencer #(
    .N_VERT(NV), .N_LINES(NL), .N_SER(NS), .FIELD_LINES(F),
    .LINE_ACT(LA), .AB_PULSES(AB), .SHUT_W(SW)
  ) dut_i (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .vstart(vstart),
    .mode_sel(mode_sel), .shutter_line(shutter_line),
    .iag1_o(iag1_o), .iag2_o(iag2_o), .sag_o(sag_o), .srg_o(srg_o),
    .abg_o(abg_o), .line_valid_o(line_valid_o), .frame_done_o(frame_done_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int div = 1, divc = 0;
  int t = 0, t_fall = 0, gap = -1, win = 0;
  int c_iag1 = 0, c_iag2 = 0, c_sag = 0, c_srg = 0, c_abg = 0, c_lv = 0, c_done = 0;
  int n_ovl = 0, n_abx = 0, n_lerr = 0, n_pair = 0;
  logic p_iag1 = 0, p_iag2 = 0, p_sag = 0, p_srg = 0, p_abg = 0, p_lv = 0, p_done = 0;
  logic in_fx = 0;

  // Enable generator: one enabled tick every div cycles
  initial forever begin
    @(negedge clk);
    if (divc >= div - 1) begin divc = 0; pix_ce = 1'b1; end
    else begin divc++; pix_ce = 1'b0; end
  end

  // Output monitor, sampled away from the active edge
  initial forever begin
    @(negedge clk);
    t++;
    if (iag1_o && !p_iag1) c_iag1++;
    if (iag2_o && !p_iag2) c_iag2++;
    if (sag_o && !p_sag) c_sag++;
    if (srg_o && !p_srg) c_srg++;
    if (abg_o && !p_abg) c_abg++;
    if (line_valid_o && !p_lv) c_lv++;
    if (frame_done_o && !p_done) c_done++;
    if (!iag1_o && p_iag1 && !p_sag) t_fall = t;
    if (sag_o && !p_sag && iag1_o) begin
      if (!in_fx) gap = t - t_fall;
      in_fx = 1'b1;
    end
    if (line_valid_o) in_fx = 1'b0;
    if (sag_o && srg_o) n_ovl++;
    if (sag_o && !p_sag && p_srg) n_ovl++;
    if (abg_o && (iag1_o || iag2_o || sag_o || srg_o)) n_abx++;
    if (iag1_o != iag2_o) n_pair++;
    if (srg_o && !p_srg) begin
      if (line_valid_o) win++; else n_lerr++;
    end
    if (!line_valid_o && p_lv) begin
      if (win != NS) n_lerr++;
      win = 0;
    end
    p_iag1 = iag1_o; p_iag2 = iag2_o; p_sag = sag_o; p_srg = srg_o;
    p_abg = abg_o; p_lv = line_valid_o; p_done = frame_done_o;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input int s, input bit m);
    @(negedge clk);
    shutter_line = SW'(s);
    mode_sel = m;
    vstart = 1'b1;
    @(negedge clk);
    vstart = 1'b0;
  endtask

  task automatic run_capture(input int s, input int d, input bit disturb);
    int b_iag1, b_iag2, b_sag, b_srg, b_abg, b_lv, b_done, b_ovl, b_abx, b_lerr, b_pair;
    int wd;
    bit sv;
    div = d;
    repeat (2 * d + 2) @(negedge clk);
    b_iag1 = c_iag1; b_iag2 = c_iag2; b_sag = c_sag; b_srg = c_srg; b_abg = c_abg;
    b_lv = c_lv; b_done = c_done; b_ovl = n_ovl; b_abx = n_abx; b_lerr = n_lerr; b_pair = n_pair;
    gap = -1;
    pulse_start(s, 1'b0);
    if (disturb) begin
      repeat (20 * d) @(negedge clk);
      pulse_start((s + 3) % F, 1'b1);   // R9: must be ignored while busy
      mode_sel = 1'b0;
    end
    wd = 0;
    while (c_done == b_done && wd < 5000) begin @(negedge clk); wd++; end
    if (wd >= 5000) check("R8 watchdog waiting for frame_done", 0, 1);
    repeat (6 * d + 4) @(negedge clk);
    sv = (s != 0) && (s < F);
    check($sformatf("%s iag1 pulses s=%0d d=%0d", sv ? "R4" : "R2", s, d), c_iag1 - b_iag1, sv ? 2 * NV : NV);
    check($sformatf("R3 iag2 pulses s=%0d", s), c_iag2 - b_iag2, sv ? 2 * NV : NV);
    check($sformatf("R3 iag phase mismatch s=%0d", s), n_pair - b_pair, 0);
    check($sformatf("R5 sag pulses s=%0d", s), c_sag - b_sag, NV + NL);
    check($sformatf("R5 srg pulses s=%0d", s), c_srg - b_srg, NL * NS);
    check($sformatf("R5 line_valid windows s=%0d", s), c_lv - b_lv, NL);
    check($sformatf("R5 per-line srg errors s=%0d", s), n_lerr - b_lerr, 0);
    check($sformatf("R6 sag/srg overlap s=%0d", s), n_ovl - b_ovl, 0);
    check($sformatf("R7 abg pulses s=%0d", s), c_abg - b_abg, F * AB);
    check($sformatf("R7 abg exclusivity s=%0d", s), n_abx - b_abx, 0);
    check($sformatf("R8 frame_done pulses s=%0d", s), c_done - b_done, 1);
    if (sv) check($sformatf("%s dump-to-transfer gap s=%0d d=%0d", d > 1 ? "R10" : "R4", s, d),
                  gap, d * (1 + (F - s) * LP));
    if (disturb) check("R9 gap after ignored restart", gap, d * (1 + (F - s) * LP));
  endtask

  task automatic run_flush(input int d);
    int b_iag1, b_sag, b_srg, b_abg, b_done;
    div = d;
    repeat (2 * d + 2) @(negedge clk);
    b_iag1 = c_iag1; b_sag = c_sag; b_srg = c_srg; b_abg = c_abg; b_done = c_done;
    pulse_start(2, 1'b1);
    mode_sel = 1'b0;
    repeat ((2 * NV + 4) * d + 10) @(negedge clk);
    check($sformatf("R3 flush iag1 pulses d=%0d", d), c_iag1 - b_iag1, NV);
    check($sformatf("R3 flush sag pulses d=%0d", d), c_sag - b_sag, 0);
    check($sformatf("R3 flush srg pulses d=%0d", d), c_srg - b_srg, 0);
    check($sformatf("R3 flush abg pulses d=%0d", d), c_abg - b_abg, 0);
    check($sformatf("R8 flush frame_done d=%0d", d), c_done - b_done, 0);
    check("R3 flush ends idle", int'(iag1_o | iag2_o | line_valid_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 global watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    // R1: idle after reset, no activity without vstart
    check("R1 gate outputs after reset", int'({iag1_o, iag2_o, sag_o, srg_o, abg_o}), 0);
    check("R1 line_valid after reset", int'(line_valid_o), 0);
    check("R1 frame_done after reset", int'(frame_done_o), 0);
    check("R1 no pulses while idle", c_iag1 + c_sag + c_srg + c_abg + c_lv, 0);
    for (int s = 0; s < (1 << SW); s++) run_capture(s, 1, 1'b0);
    run_capture(2, 3, 1'b0);
    run_capture(0, 2, 1'b0);
    run_capture(4, 3, 1'b0);
    run_capture(3, 1, 1'b1);
    run_flush(1);
    run_flush(3);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule